// File: doc/BRIEF.md
# SDRAM Chip-Select Window Decoder

This block turns a 36-bit CPU physical address into a choice among four SDRAM chip-select windows. Each chip select has a base register and a size register, which software programs through a 32-bit register port. The lookup port is combinational on the registered window state. It reports whether the address falls inside an enabled window, which chip select was chosen, the SDRAM target id, and an attribute code for that chip select.

The block also gives a status view of the chip selects that a device with only 32 address bits can reach. That view is a mask with one bit per chip select, plus a count of its set bits. Windows are 16 MiB aligned. A size mask marks the address bits 31:24 that the match ignores, so a window spans a power-of-two number of 16 MiB units.

Top module: `sdram_cs_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled, no lookup hits, and the reachable mask and count are zero.
- R2: Registers are selected by `reg_addr[5:2]`. The base register of chip select n sits at byte offset 8n and its size register at 8n+4. A base register keeps bits 31:24 (address bits 31:24) and bits 3:0 (address bits 35:32). A size register keeps bits 31:24 (size mask), bits 4:2 (chip-select field) and bit 0 (enable). All other bits read back as zero.
- R3: Byte offsets 0x20 to 0x3C read as zero, and writes to them change no register.
- R4: An address hits chip select n when all three of these hold: n is enabled; address bits 35:32 equal the high base bits; and address bits 31:24 equal base bits 31:24 at every position where the size mask bit is 0. The window size is the size mask followed by 24 one bits, plus one.
- R5: A window whose enable bit is 0 never hits, whatever its base and size.
- R6: When several windows hit, the lowest chip-select index is reported.
- R7: On a hit the attribute is 4'hF with bit n cleared, where n is the chosen chip select. The target id is always 0.
- R8: On a miss, `lk_hit` is 0 and both `lk_cs` and `lk_attr` are 0.
- R9: Bit n of `reach_mask` is 1 exactly when chip select n is enabled and its high base bits are zero. `reach_cnt` is the number of set bits in `reach_mask`.
- R10: A register write takes effect at the clock edge that samples it. A lookup in the same cycle sees the window state from before the write, and the status view changes only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lk_addr | input | 36 | Physical address to decode |
| lk_hit | output | 1 | Address falls in an enabled window |
| lk_cs | output | 2 | Chosen chip-select index |
| lk_target | output | 4 | SDRAM target id (always 0) |
| lk_attr | output | 4 | Attribute code of the chosen chip select |
| reach_mask | output | 4 | Chip selects reachable with 32-bit addresses |
| reach_cnt | output | 3 | Number of set bits in `reach_mask` |

## Verification
A register write and a lookup of the same window can fall in the same cycle. The bench provokes this by holding a lookup address inside chip select 1 while it drives a write that disables chip select 1. A wider window on chip select 3 covers the same address. Before the clock edge the lookup must still report chip select 1. After the edge it must report chip select 3, and the reachable mask and count must drop by one at that edge.

// File: rtl/sdram_cs_pkg.sv
package sdram_cs_pkg;

  // One chip-select window as held in the register file
  typedef struct packed {
    logic [3:0] bhi;    // address bits 35:32
    logic [7:0] blo;    // address bits 31:24
    logic [7:0] smask;  // don't-care mask over address bits 31:24
    logic [2:0] csf;    // chip-select field, stored only
    logic       en;
  } cs_win_t;

  function automatic logic [31:0] pack_base(input cs_win_t w);
    return {w.blo, 20'd0, w.bhi};
  endfunction

  function automatic logic [31:0] pack_size(input cs_win_t w);
    return {w.smask, 19'd0, w.csf, 1'b0, w.en};
  endfunction

  // Match: enabled, high bits equal, low byte equal outside the mask
  function automatic logic win_hit(input cs_win_t w, input logic [35:0] a);
    return w.en && (a[35:32] == w.bhi) &&
           (((a[31:24] ^ w.blo) & ~w.smask) == 8'd0);
  endfunction

  function automatic logic win_low32(input cs_win_t w);
    return w.en && (w.bhi == 4'd0);
  endfunction

endpackage

// File: rtl/sdram_cs_regfile.sv
module sdram_cs_regfile
  import sdram_cs_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output cs_win_t        win [NCS]
);
  localparam int IW   = AW - 2;
  localparam int CSW  = $clog2(NCS);
  localparam logic [IW-1:0] NREG = IW'(2 * NCS);

  logic [IW-1:0]  widx;
  logic           in_map;
  logic [CSW-1:0] csn;

  assign widx   = addr[AW-1:2];
  assign in_map = (widx < NREG);
  assign csn    = widx[CSW:1];

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    localparam logic [CSW-1:0] GI = CSW'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win[g] <= '0;
      end else if (we && in_map && (csn == GI)) begin
        if (widx[0]) begin
          win[g].smask <= wdata[31:24];
          win[g].csf   <= wdata[4:2];
          win[g].en    <= wdata[0];
        end else begin
          win[g].blo <= wdata[31:24];
          win[g].bhi <= wdata[3:0];
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (in_map)
      rdata = widx[0] ? pack_size(win[csn]) : pack_base(win[csn]);
  end
endmodule

// File: rtl/sdram_cs_match.sv
module sdram_cs_match
  import sdram_cs_pkg::*;
#(
  parameter int NCS = 4
) (
  input  cs_win_t        win [NCS],
  input  logic [35:0]    addr,
  output logic [NCS-1:0] hit_vec,
  output logic [NCS-1:0] low_vec
);
  for (genvar g = 0; g < NCS; g++) begin : g_m
    assign hit_vec[g] = win_hit(win[g], addr);
    assign low_vec[g] = win_low32(win[g]);
  end
endmodule

// File: rtl/sdram_cs_select.sv
module sdram_cs_select #(
  parameter int NCS  = 4,
  localparam int CSW  = $clog2(NCS),
  localparam int CNTW = $clog2(NCS + 1)
) (
  input  logic [NCS-1:0]  hit_vec,
  input  logic [NCS-1:0]  low_vec,
  output logic            hit,
  output logic [CSW-1:0]  cs,
  output logic [NCS-1:0]  attr,
  output logic [CNTW-1:0] cnt
);
  always_comb begin
    cs = '0;
    for (int i = NCS - 1; i >= 0; i--)
      if (hit_vec[i]) cs = CSW'(i);
  end

  assign hit  = |hit_vec;
  assign attr = hit ? ~(NCS'(1) << cs) : '0;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NCS; i++)
      cnt = cnt + CNTW'(low_vec[i]);
  end
endmodule

// File: rtl/sdram_cs_decoder.sv
module sdram_cs_decoder
  import sdram_cs_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 6,
  localparam int CSW  = $clog2(NCS),
  localparam int CNTW = $clog2(NCS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [AW-1:0]   reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [35:0]     lk_addr,
  output logic            lk_hit,
  output logic [CSW-1:0]  lk_cs,
  output logic [3:0]      lk_target,
  output logic [NCS-1:0]  lk_attr,
  output logic [NCS-1:0]  reach_mask,
  output logic [CNTW-1:0] reach_cnt
);
  cs_win_t        win [NCS];
  logic [NCS-1:0] hit_vec;

  sdram_cs_regfile #(.NCS(NCS), .AW(AW)) rf_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .win(win)
  );

  sdram_cs_match #(.NCS(NCS)) m_i (
    .win(win), .addr(lk_addr), .hit_vec(hit_vec), .low_vec(reach_mask)
  );

  sdram_cs_select #(.NCS(NCS)) s_i (
    .hit_vec(hit_vec), .low_vec(reach_mask), .hit(lk_hit),
    .cs(lk_cs), .attr(lk_attr), .cnt(reach_cnt)
  );

  assign lk_target = 4'd0;
endmodule

// File: rtl/sdram_cs_decoder_chk.sv
module sdram_cs_decoder_chk #(
  parameter int NCS = 4,
  localparam int CSW  = $clog2(NCS),
  localparam int CNTW = $clog2(NCS + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic            lk_hit,
  input logic [CSW-1:0]  lk_cs,
  input logic [3:0]      lk_target,
  input logic [NCS-1:0]  lk_attr,
  input logic [NCS-1:0]  reach_mask,
  input logic [CNTW-1:0] reach_cnt,
  input logic [NCS-1:0]  hit_vec
);
  assert_hit_any_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit == (|hit_vec));

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (hit_vec[lk_cs] &&
                ((hit_vec & ((NCS'(1) << lk_cs) - NCS'(1))) == '0)));

  assert_attr_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (!lk_attr[lk_cs] && ($countones(lk_attr) == NCS - 1)));

  assert_target_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_target == 4'd0);

  assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_attr == '0 && lk_cs == '0));

  assert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(reach_cnt) == $countones(reach_mask));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reach_mask));
endmodule

bind sdram_cs_decoder sdram_cs_decoder_chk #(.NCS(NCS)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .lk_hit(lk_hit),
  .lk_cs(lk_cs), .lk_target(lk_target), .lk_attr(lk_attr),
  .reach_mask(reach_mask), .reach_cnt(reach_cnt), .hit_vec(hit_vec)
);

// File: tb/sdram_cs_decoder_tb_top.sv
module sdram_cs_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [35:0] lk_addr = '0;
  logic        lk_hit;
  logic [1:0]  lk_cs;
  logic [3:0]  lk_target;
  logic [3:0]  lk_attr;
  logic [3:0]  reach_mask;
  logic [2:0]  reach_cnt;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] sh_base [4];
  logic [31:0] sh_size [4];

  always #10 clk = ~clk;

  sdram_cs_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_cs(lk_cs), .lk_target(lk_target),
    .lk_attr(lk_attr), .reach_mask(reach_mask), .reach_cnt(reach_cnt)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shadow_update(input logic [5:0] a, input logic [31:0] d);
    if (a < 6'h20) begin
      if (a[2]) sh_size[a[4:3]] = d & 32'hFF00_001D;
      else      sh_base[a[4:3]] = d & 32'hFF00_000F;
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    shadow_update(a, d);
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  // Range-based model: base <= addr < base + size with high bits equal
  task automatic look(input string tag, input logic [35:0] a);
    logic       eh;
    logic [1:0] ec;
    logic [3:0] ea;
    eh = 1'b0; ec = '0; ea = '0;
    for (int i = 3; i >= 0; i--) begin
      logic [32:0] lo, sz;
      lo = {1'b0, sh_base[i][31:24], 24'h0};
      sz = {1'b0, sh_size[i][31:24], 24'hFF_FFFF} + 33'd1;
      if (sh_size[i][0] && a[35:32] == sh_base[i][3:0] &&
          {1'b0, a[31:0]} >= lo && {1'b0, a[31:0]} < lo + sz) begin
        eh = 1'b1; ec = 2'(i); ea = 4'hF & ~(4'b1 << i);
      end
    end
    lk_addr = a;
    #1;
    check({tag, " hit"}, lk_hit, eh);
    check({tag, " cs"}, lk_cs, ec);
    check({tag, " attr"}, lk_attr, ea);
    check({tag, " target R7"}, lk_target, 0);
  endtask

  task automatic reach(input string tag);
    logic [3:0] m;
    int c;
    c = 0;
    for (int i = 0; i < 4; i++) begin
      m[i] = sh_size[i][0] && (sh_base[i][3:0] == 4'd0);
      c += int'(m[i]);
    end
    #1;
    check({tag, " mask"}, reach_mask, m);
    check({tag, " cnt"}, reach_cnt, c);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 16; i++) rd("R1 reset readback", 6'(i * 4), 32'h0);
    look("R1 reset lookup", 36'h0_0000_0000);
    reach("R1 reset reach");
  endtask

  task automatic t_regmap;
    wr(6'h00, 32'hFFFF_FFFF);
    rd("R2 base field mask", 6'h00, 32'hFF00_000F);
    wr(6'h04, 32'hFFFF_FFFF);
    rd("R2 size field mask", 6'h04, 32'hFF00_001D);
    wr(6'h1C, 32'hA5A5_A5A5);
    rd("R2 size3 offset", 6'h1C, 32'hA500_0005);
    rd("R2 base3 untouched", 6'h18, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF);
    rd("R3 unused reads zero", 6'h24, 32'h0);
    rd("R3 base1 untouched", 6'h08, 32'h0);
    rd("R3 size1 untouched", 6'h0C, 32'h0);
    wr(6'h00, 32'h0); wr(6'h04, 32'h0); wr(6'h1C, 32'h0);
    reach("R9 after clear");
  endtask

  task automatic t_lookup;
    wr(6'h00, 32'h0000_0000); wr(6'h04, 32'h0F00_0001); // cs0 0..256M
    wr(6'h08, 32'h1000_0000); wr(6'h0C, 32'h0F00_0005); // cs1 256M..512M
    wr(6'h10, 32'h0000_0001); wr(6'h14, 32'h0000_0009); // cs2 high=1, 16M
    wr(6'h18, 32'h4000_0000); wr(6'h1C, 32'h3F00_0000); // cs3 disabled
    look("R4 cs0 inside", 36'h0_0800_0000);
    look("R4 cs1 top edge", 36'h0_1FFF_FFFF);
    look("R4 cs1 bottom edge", 36'h0_1000_0000);
    look("R4 cs2 high bits", 36'h1_00AB_CDEF);
    look("R8 cs2 past end", 36'h1_0100_0000);
    look("R8 above cs1", 36'h0_2000_0000);
    look("R8 wrong high bits", 36'h2_0800_0000);
    look("R5 disabled cs3", 36'h0_4000_0000);
    reach("R9 mixed");
  endtask

  task automatic t_priority;
    wr(6'h18, 32'h0000_0000); wr(6'h1C, 32'hFF00_000D); // cs3 full 4G
    look("R6 cs0 over cs3", 36'h0_0800_0000);
    look("R6 cs1 over cs3", 36'h0_1800_0000);
    look("R7 cs3 attr", 36'h0_4000_0000);
    reach("R9 cs3 on");
    wr(6'h04, 32'h0F00_0000);                          // disable cs0
    look("R5 cs0 off falls to cs3", 36'h0_0800_0000);
    reach("R9 cs0 off");
  endtask

  task automatic t_same_cycle;
    lk_addr = 36'h0_1000_0000;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'h0C; reg_wdata = 32'h0F00_0004;
    #1;
    check("R10 pre-edge cs", lk_cs, 2'd1);
    check("R10 pre-edge attr", lk_attr, 4'hD);
    reach("R10 pre-edge");
    @(negedge clk);
    reg_we = 1'b0;
    shadow_update(6'h0C, 32'h0F00_0004);
    #1;
    check("R10 post-edge cs", lk_cs, 2'd3);
    check("R10 post-edge attr", lk_attr, 4'h7);
    reach("R10 post-edge");
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin sh_base[i] = '0; sh_size[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_lookup;
    t_priority;
    t_same_cycle;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule